// File: doc/BRIEF.md
# Lockable Watchdog Timer

A supervisory timer that software arms once and must then service regularly. After the enable bit is set, a down-counter loaded from a programmable timeout moves one step every fourth clock. If it runs out, or if software performs a malformed reload, the block raises a timeout event. Depending on a mode bit, the event is either a one-cycle system reset request or a level interrupt. Both the enable bit and the mode bit can only be set by software. They clear only on power-on reset or on the block's own timeout event.

Software services the timer with a two-write reload handshake on a dedicated register. The first write carries 0xAA. The very next register access must write 0x55 to the same register. Anything else breaks the handshake and counts as a timeout. A sticky flag records that a reset request was issued. It survives the block's own reset action and clears only on power-on reset or by a software write-one. While a debug halt input is high, the countdown stops.

The register port is a single-cycle bus. There are four word registers: control (0), timeout (1), reload (2) and current count (3, read-only).

Top module: `wdt_lockable`

## Requirements
- R1: After power-on reset (rst_ni low), control reads 0, timeout reads 0xFF, count reads 0, and both wdt_rst_o and wdt_irq_o are low.
- R2: A write to the timeout register (address 1) stores the written value, except that values below 0xFF are stored as 0xFF. A read returns the stored value.
- R3: Setting control bit 0 (enable) loads the count from the timeout value T and clears the divide-by-4 prescaler. The timeout event becomes visible on the outputs exactly 4*T clock edges after the edge that accepted the enable write.
- R4: Control bit 0 (enable) and bit 1 (reset mode) can only be set by a write. Writing 0 to them has no effect. They clear only on power-on reset or on a timeout event.
- R5: While enabled, writing 0xAA and then 0x55 to address 2 on two consecutive register accesses reloads the count from the timeout value and restarts the prescaler. The next event then comes 4*T edges after the 0x55 write.
- R6: While enabled, any of the following is a bad reload and raises a timeout event at the edge that accepts the access:
  - any register access other than a 0x55 write to address 2 directly after a 0xAA write to address 2;
  - a write to address 2 of any value other than 0xAA when no handshake is pending.
  While disabled, such accesses have no effect.
- R7: In reset mode, a timeout event pulses wdt_rst_o high for exactly one cycle. It also clears enable and reset mode, returns the timeout register to 0xFF, and sets control bit 2 (reset flag).
- R8: With reset mode clear, a timeout event sets control bit 3 and clears enable. wdt_irq_o follows bit 3 and stays high until software writes 1 to bit 3.
- R9: Writing 1 to control bit 2 clears the reset flag. Writing 0 leaves it unchanged.
- R10: While dbg_halt_i is high, the count and the prescaler hold. Each halted cycle delays the event by one cycle.
- R11: Address 3 reads the current count, zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Watchdog clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| req_i | input | 1 | Register access strobe, one access per cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 2 | Word register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| dbg_halt_i | input | 1 | Freeze the countdown |
| wdt_rst_o | output | 1 | One-cycle system reset request |
| wdt_irq_o | output | 1 | Timeout interrupt, level |

## Verification
The timeout path is tried with programmed values below, at and above the 0xFF floor, in both reset and interrupt mode. Measuring the event latency in clock edges separates a correct clamp from a missing one, and a correct prescaler from an off-by-one in the expiry compare. Reload handshakes are tried in four forms: correct, with a wrong second value, with an intervening read, and with an unarmed non-0xAA write. These separate a proper reload from a spurious reset, and also confirm that the same patterns are harmless while disabled. Debug halt, the set-only lock bits and the write-one-to-clear flags are each checked through register reads after the stimulus.

// File: rtl/wdt_lock_pkg.sv
package wdt_lock_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_TMO  = 2'd1,
    REG_FEED = 2'd2,
    REG_CNT  = 2'd3
  } wdt_reg_e;

  localparam int unsigned CTRL_EN    = 0;
  localparam int unsigned CTRL_MODE  = 1;
  localparam int unsigned CTRL_RFLAG = 2;
  localparam int unsigned CTRL_IRQ   = 3;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int unsigned DIV_LOG2 = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic restart_i,
  output logic tick_o
);
  logic [DIV_LOG2-1:0] div_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        div_q <= '0;
    else if (restart_i) div_q <= '0;
    else if (run_i)     div_q <= div_q + 1'b1;
  end

  assign tick_o = run_i && (div_q == '1);

  a_r3_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o);
endmodule

// File: rtl/wdt_feed_seq.sv
module wdt_feed_seq #(
  parameter int unsigned        DATA_W = 32,
  parameter logic [DATA_W-1:0]  KEY1   = 'hAA,
  parameter logic [DATA_W-1:0]  KEY2   = 'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              acc_i,
  input  logic              feed_wr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              ok_o,
  output logic              bad_o
);
  logic armed_q;

  always_comb begin
    ok_o  = armed_q && feed_wr_i && (data_i == KEY2);
    bad_o = armed_q ? (acc_i && !ok_o) : (feed_wr_i && (data_i != KEY1));
  end

  // any access ends a pending handshake; only a first-key write opens one
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    armed_q <= 1'b0;
    else if (acc_i) armed_q <= !armed_q && feed_wr_i && (data_i == KEY1);
  end

  a_r6_one_shot_arm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && acc_i) |=> !armed_q);
endmodule

// File: rtl/wdt_downcounter.sv
module wdt_downcounter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_o    = cnt_q;
  assign expire_o = tick_i && (cnt_q == CNT_W'(1));

  a_r10_hold_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !load_i && !clear_i) |=> $stable(cnt_q));
  a_r3_step_on_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !load_i && !clear_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1);
endmodule

// File: rtl/wdt_lockable.sv
module wdt_lockable
  import wdt_lock_pkg::*;
#(
  parameter int unsigned       DATA_W   = 32,
  parameter int unsigned       CNT_W    = 32,
  parameter int unsigned       DIV_LOG2 = 2,
  parameter int unsigned       MIN_TMO  = 32'hFF,
  parameter logic [DATA_W-1:0] KEY1     = 'hAA,
  parameter logic [DATA_W-1:0] KEY2     = 'h55
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              dbg_halt_i,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  localparam logic [CNT_W-1:0] TMO_FLOOR = CNT_W'(MIN_TMO);

  logic en_q, mode_q, rflag_q, irq_q, rst_q;
  logic [CNT_W-1:0] tmo_q, cnt;
  logic wr, ctrl_wr, tmo_wr, feed_wr;
  logic feed_ok, feed_bad, expire, tick, evt, en_set, reload;

  assign wr      = req_i && we_i;
  assign ctrl_wr = wr && (addr_i == REG_CTRL);
  assign tmo_wr  = wr && (addr_i == REG_TMO);
  assign feed_wr = wr && (addr_i == REG_FEED);
  assign en_set  = ctrl_wr && wdata_i[CTRL_EN] && !en_q;
  assign evt     = en_q && (expire || feed_bad);
  assign reload  = en_set || (en_q && feed_ok);

  wdt_feed_seq #(.DATA_W(DATA_W), .KEY1(KEY1), .KEY2(KEY2)) u_feed (
    .clk_i, .rst_ni, .acc_i(req_i), .feed_wr_i(feed_wr), .data_i(wdata_i),
    .ok_o(feed_ok), .bad_o(feed_bad)
  );

  wdt_prescaler #(.DIV_LOG2(DIV_LOG2)) u_pre (
    .clk_i, .rst_ni, .run_i(en_q && !dbg_halt_i), .restart_i(reload), .tick_o(tick)
  );

  wdt_downcounter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni, .clear_i(evt), .load_i(reload), .load_val_i(tmo_q),
    .tick_i(tick), .cnt_o(cnt), .expire_o(expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      rflag_q <= 1'b0;
      irq_q   <= 1'b0;
      rst_q   <= 1'b0;
      tmo_q   <= TMO_FLOOR;
    end else begin
      rst_q <= evt && mode_q;
      if (evt) begin
        en_q <= 1'b0;
        if (mode_q) begin
          // self-reset: everything but the sticky flag
          mode_q  <= 1'b0;
          tmo_q   <= TMO_FLOOR;
          rflag_q <= 1'b1;
        end else begin
          irq_q <= 1'b1;
        end
      end else begin
        if (ctrl_wr) begin
          if (wdata_i[CTRL_EN])    en_q    <= 1'b1;
          if (wdata_i[CTRL_MODE])  mode_q  <= 1'b1;
          if (wdata_i[CTRL_RFLAG]) rflag_q <= 1'b0;
          if (wdata_i[CTRL_IRQ])   irq_q   <= 1'b0;
        end
        if (tmo_wr)
          tmo_q <= (wdata_i[CNT_W-1:0] < TMO_FLOOR) ? TMO_FLOOR : wdata_i[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (wdt_reg_e'(addr_i))
      REG_CTRL: rdata_o = DATA_W'({irq_q, rflag_q, mode_q, en_q});
      REG_TMO:  rdata_o = DATA_W'(tmo_q);
      REG_FEED: rdata_o = '0;
      REG_CNT:  rdata_o = DATA_W'(cnt);
      default:  rdata_o = '0;
    endcase
  end

  assign wdt_rst_o = rst_q;
  assign wdt_irq_o = irq_q;

  a_r4_enable_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !evt) |=> en_q);
  a_r4_mode_locked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q && !evt) |=> mode_q);
  a_r7_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o);
  a_r7_flag_with_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |-> (rflag_q && !en_q && !mode_q));
  a_r2_timeout_floor: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmo_q >= TMO_FLOOR);
  a_r5_reload_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && feed_ok && !evt) |=> cnt == $past(tmo_q));
  a_r8_irq_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wdt_irq_o && !(ctrl_wr && wdata_i[CTRL_IRQ])) |=> wdt_irq_o);
endmodule

// File: tb/wdt_lockable_tb.sv
module wdt_lockable_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0, dbg_halt_i = 1'b0;
  logic [1:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        wdt_rst_o, wdt_irq_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk_i = ~clk_i;

  wdt_lockable u_dut (.*);

  // {programmed, effective, reset_mode}
  localparam logic [64:0] TBL [0:5] = '{
    {32'h0000_0000, 32'h0000_00FF, 1'b1},
    {32'h0000_0010, 32'h0000_00FF, 1'b0},
    {32'h0000_00FE, 32'h0000_00FF, 1'b1},
    {32'h0000_00FF, 32'h0000_00FF, 1'b0},
    {32'h0000_0100, 32'h0000_0100, 1'b1},
    {32'h0000_0123, 32'h0000_0123, 1'b0}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic por();
    @(negedge clk_i);
    rst_ni = 1'b0; req_i = 1'b0; dbg_halt_i = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  task automatic wait_evt(input bit use_rst, inout int k);
    while (!(use_rst ? wdt_rst_o : wdt_irq_o) && k < 40000) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_i);
  endtask

  initial begin
    #1_500_000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int k;

    // R1 reset state
    por();
    rd(2'd0, d); check("R1 ctrl", d, 32'h0);
    rd(2'd1, d); check("R1 tmo", d, 32'hFF);
    rd(2'd3, d); check("R1 cnt", d, 32'h0);
    check("R1 rst_o", {31'b0, wdt_rst_o}, 32'h0);
    check("R1 irq_o", {31'b0, wdt_irq_o}, 32'h0);

    // R2 clamp, R3 latency, R7/R8 outcome per table row
    for (int i = 0; i < 6; i++) begin
      logic [31:0] prog, eff;
      logic        rm;
      {prog, eff, rm} = TBL[i];
      por();
      wr(2'd1, prog);
      rd(2'd1, d); check("R2 clamp", d, eff);
      wr(2'd0, rm ? 32'h3 : 32'h1);
      k = 0;
      wait_evt(rm, k);
      check("R3 latency", k, 4 * eff);
      @(negedge clk_i);
      if (rm) begin
        check("R7 pulse ends", {31'b0, wdt_rst_o}, 32'h0);
        rd(2'd0, d); check("R7 ctrl after", d, 32'h4);
        rd(2'd1, d); check("R7 tmo restored", d, 32'hFF);
      end else begin
        check("R8 irq held", {31'b0, wdt_irq_o}, 32'h1);
        rd(2'd0, d); check("R8 ctrl after", d, 32'h8);
      end
    end

    // R4, R11, R5, R7, R9
    por();
    wr(2'd1, 32'h200);
    wr(2'd0, 32'h1);
    rd(2'd3, d); check("R11 cnt", d, 32'h200);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R4 enable sticky", d, 32'h1);
    wr(2'd0, 32'h2);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R4 mode sticky", d, 32'h3);
    idle(1500);
    check("R5 no early event", {30'b0, wdt_rst_o, wdt_irq_o}, 32'h0);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h55);
    k = 0;
    wait_evt(1'b1, k);
    check("R5 reload latency", k, 4 * 32'h200);
    @(negedge clk_i);
    rd(2'd0, d); check("R7 flag survives", d, 32'h4);
    wr(2'd0, 32'h0);
    rd(2'd0, d); check("R9 write0 keeps", d, 32'h4);
    wr(2'd0, 32'h4);
    rd(2'd0, d); check("R9 w1c", d, 32'h0);

    // R6 read between keys
    por();
    wr(2'd0, 32'h3);
    wr(2'd2, 32'hAA);
    rd(2'd0, d);
    check("R6 read breaks", {31'b0, wdt_rst_o}, 32'h1);
    rd(2'd0, d); check("R6 ctrl", d, 32'h4);

    // R6 wrong second key, R8 clear
    por();
    wr(2'd0, 32'h1);
    wr(2'd2, 32'hAA);
    wr(2'd2, 32'h56);
    check("R6 wrong key", {31'b0, wdt_irq_o}, 32'h1);
    wr(2'd0, 32'h8);
    check("R8 irq cleared", {31'b0, wdt_irq_o}, 32'h0);

    // R6 unarmed non-first key
    por();
    wr(2'd0, 32'h3);
    wr(2'd2, 32'h55);
    check("R6 unarmed", {31'b0, wdt_rst_o}, 32'h1);

    // R6 ignored while disabled
    por();
    wr(2'd2, 32'hAA);
    rd(2'd0, d);
    wr(2'd2, 32'h12);
    check("R6 disabled outs", {30'b0, wdt_rst_o, wdt_irq_o}, 32'h0);
    rd(2'd0, d); check("R6 disabled ctrl", d, 32'h0);

    // R10 debug halt
    por();
    wr(2'd1, 32'h100);
    wr(2'd0, 32'h1);
    dbg_halt_i = 1'b1;
    k = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      k++;
    end
    dbg_halt_i = 1'b0;
    wait_evt(1'b0, k);
    check("R10 halt delay", k, 4 * 32'h100 + 300);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule